// File: doc/BRIEF.md
# Port Interrupt Route Steering Unit

This unit takes the pending-interrupt flags of the pins of one port (at most eight pins) and steers them onto eight interrupt routes. Each route owns a pin mask. A pin contributes to a route only when its bit is set in that route's mask. For every route the unit keeps a registered status bitmap, which software can read, and drives one interrupt line. That line is high whenever any bit of the bitmap is set.

After reset, a sequencer loads each route mask with the default, in which every implemented pin is selected. It loads one route per cycle. The masks are reached through a small register window. A security control word in the same window holds two sticky lock bits. One lock hides the masks from reads. The other, or either of the two, freezes the masks against reprogramming.

A lock controller with five states governs access to the masks:
- INIT: the default masks are being loaded. It moves to OPEN after the last route.
- OPEN: no lock is set and the masks can be written. A control write moves it to WLOCK (write lock only), to RLOCK (read lock only) or to SEALED (both locks).
- WLOCK: only the write lock is set. Setting the read lock moves it to SEALED.
- RLOCK: only the read lock is set. Setting the write lock moves it to SEALED.
- SEALED: both locks are set. Only reset leaves this state.

Top module: `gpio_port_irq_router`

## Requirements
- R1: During reset every route line is low. After reset is released, the sequencer loads mask r in cycle r. Once NROUTES cycles have passed, each mask reads as the low NPINS bits set (0x7F for seven pins). Bus writes made during these cycles are ignored.
- R2: Mask register r sits at byte address 0x14 + PORT_IDX·0x20 + 4·r. While no lock is set, a write stores wdata[7:0] in it, and a read returns the stored mask in bits 7:0 with zeros above.
- R3: The security control word sits at byte address 0x0C. Writing a 1 to bit 28 sets the write lock, and writing a 1 to bit 27 sets the read lock. Writing a 0 to either bit has no effect. Both bits read back at the same positions and stay set until reset.
- R4: While either lock is set, writes to the mask registers are ignored. The bench observes this through the status and the route lines.
- R5: While the read lock is set, reads of the mask registers return zero.
- R6: Status r sits at byte address 0x100 + 4·r. One clock edge after the pending flags are sampled, it holds those flags ANDed with mask r.
- R7: Status bits at positions NPINS and above always read as zero, whatever the mask and pending values are.
- R8: Route line r is the OR of status r and is updated on the same edge as the status. If no flag was pending on the previous edge, every line is low.
- R9: Reads of addresses outside the control word, the mask registers and the status registers return zero. Writes to the status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_pending | input | 8 | Pending-interrupt flag per pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Byte address of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr (combinational) |
| route_irq | output | 8 | One interrupt line per route |

## Verification
The assertions assume that the pending flags are driven to known values on every clock from reset onward. They also assume that reg_addr is always a defined value, because the read lock is checked against whatever address is presented. The bench drives every input half a cycle away from the rising edge and holds it steady across that edge. It zeroes the pending flags during reset and steps through lock combinations only in the order the controller permits. It uses reset to return to the unlocked state between phases.

// File: rtl/gpio_rt_pkg.sv
package gpio_rt_pkg;
    localparam int PINS_MAX        = 8;
    localparam int ROUTES          = 8;
    localparam int SCR_OFS         = 'h00C;
    localparam int MAP_BASE        = 'h014;
    localparam int MAP_PORT_STRIDE = 'h020;
    localparam int REG_STEP        = 4;
    localparam int STAT_BASE       = 'h100;
    localparam int WLOCK_BIT       = 28;
    localparam int RLOCK_BIT       = 27;

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_OPEN   = 3'd1,
        ST_WLOCK  = 3'd2,
        ST_RLOCK  = 3'd3,
        ST_SEALED = 3'd4
    } rt_state_e;
endpackage

// File: rtl/gpio_rt_lock_fsm.sv
module gpio_rt_lock_fsm
    import gpio_rt_pkg::*;
#(
    parameter int NROUTES = ROUTES,
    parameter int IDX_W   = $clog2(NROUTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scr_wr,
    input  logic             set_w,
    input  logic             set_r,
    output logic             init_we,
    output logic [IDX_W-1:0] init_idx,
    output logic             map_open,
    output logic             wlock,
    output logic             rlock
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NROUTES - 1);

    rt_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (idx_q == LAST_IDX) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (scr_wr) begin
                    if (set_w && set_r) state_d = ST_SEALED;
                    else if (set_w)     state_d = ST_WLOCK;
                    else if (set_r)     state_d = ST_RLOCK;
                end
            end
            ST_WLOCK: begin
                if (scr_wr && set_r) state_d = ST_SEALED;
            end
            ST_RLOCK: begin
                if (scr_wr && set_w) state_d = ST_SEALED;
            end
            ST_SEALED: state_d = ST_SEALED;
            default:   state_d = ST_INIT;
        endcase
    end

    always_comb begin
        init_we  = 1'b0;
        map_open = 1'b0;
        wlock    = 1'b0;
        rlock    = 1'b0;
        unique case (state_q)
            ST_INIT:   init_we  = 1'b1;
            ST_OPEN:   map_open = 1'b1;
            ST_WLOCK:  wlock    = 1'b1;
            ST_RLOCK:  rlock    = 1'b1;
            ST_SEALED: begin
                wlock = 1'b1;
                rlock = 1'b1;
            end
            default: init_we = 1'b0;
        endcase
    end

    assign init_idx = idx_q;

    assert_wlock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wlock |=> wlock);
    assert_rlock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rlock |=> rlock);
    assert_init_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |-> (!wlock && !rlock && !map_open));
endmodule

// File: rtl/gpio_rt_mask_bank.sv
module gpio_rt_mask_bank #(
    parameter int NROUTES = 8,
    parameter int WIDTH   = 8,
    parameter int IDX_W   = $clog2(NROUTES),
    parameter logic [WIDTH-1:0] DEFAULT_MASK = '1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           init_we,
    input  logic [IDX_W-1:0]               init_idx,
    input  logic                           host_we,
    input  logic [IDX_W-1:0]               host_idx,
    input  logic [WIDTH-1:0]               host_data,
    output logic [NROUTES-1:0][WIDTH-1:0]  masks
);
    for (genvar r = 0; r < NROUTES; r++) begin : g_route
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                masks[r] <= '0;
            end else if (init_we && init_idx == IDX_W'(r)) begin
                masks[r] <= DEFAULT_MASK;
            end else if (host_we && host_idx == IDX_W'(r)) begin
                masks[r] <= host_data;
            end
        end
    end

    assert_mask_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_we && !host_we) |=> $stable(masks));
endmodule

// File: rtl/gpio_rt_status.sv
module gpio_rt_status #(
    parameter int NROUTES = 8,
    parameter int WIDTH   = 8,
    parameter int NPINS   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [WIDTH-1:0]               pending,
    input  logic [NROUTES-1:0][WIDTH-1:0]  masks,
    output logic [NROUTES-1:0][WIDTH-1:0]  status_q,
    output logic [NROUTES-1:0]             irq_q
);
    localparam logic [WIDTH-1:0] LIVE = WIDTH'((64'd1 << NPINS) - 64'd1);

    for (genvar r = 0; r < NROUTES; r++) begin : g_route
        logic [WIDTH-1:0] hit;
        assign hit = pending & masks[r] & LIVE;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[r] <= '0;
                irq_q[r]    <= 1'b0;
            end else begin
                status_q[r] <= hit;
                irq_q[r]    <= |hit;
            end
        end

        if (NPINS < WIDTH) begin : g_top_clear
            assert_top_bits_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
                status_q[r][WIDTH-1:NPINS] == '0);
        end
    end

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> (irq_q == '0));
endmodule

// File: rtl/gpio_port_irq_router.sv
module gpio_port_irq_router
    import gpio_rt_pkg::*;
#(
    parameter int NPINS    = 7,
    parameter int PORT_IDX = 0,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PINS_MAX-1:0] pin_pending,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [ROUTES-1:0]   route_irq
);
    localparam int IDX_W = $clog2(ROUTES);
    localparam logic [ADDR_W-1:0] SCR_A   = ADDR_W'(SCR_OFS);
    localparam logic [ADDR_W-1:0] MAP_LO  = ADDR_W'(MAP_BASE + PORT_IDX * MAP_PORT_STRIDE);
    localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(STAT_BASE);
    localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(ROUTES * REG_STEP);
    localparam logic [PINS_MAX-1:0] DEF_MASK = PINS_MAX'((64'd1 << NPINS) - 64'd1);

    logic [ADDR_W-1:0] map_off, stat_off;
    logic              scr_hit, map_hit, stat_hit;
    logic [IDX_W-1:0]  map_idx, stat_idx;

    assign map_off  = reg_addr - MAP_LO;
    assign stat_off = reg_addr - STAT_LO;
    assign scr_hit  = (reg_addr == SCR_A);
    assign map_hit  = (reg_addr >= MAP_LO) && (map_off < SPAN) && (map_off[1:0] == 2'b00);
    assign stat_hit = (reg_addr >= STAT_LO) && (stat_off < SPAN) && (stat_off[1:0] == 2'b00);
    assign map_idx  = map_off[IDX_W+1:2];
    assign stat_idx = stat_off[IDX_W+1:2];

    logic             init_we, map_open, wlock, rlock;
    logic [IDX_W-1:0] init_idx;

    gpio_rt_lock_fsm #(.NROUTES(ROUTES), .IDX_W(IDX_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .scr_wr   (reg_wr && scr_hit),
        .set_w    (reg_wdata[WLOCK_BIT]),
        .set_r    (reg_wdata[RLOCK_BIT]),
        .init_we  (init_we),
        .init_idx (init_idx),
        .map_open (map_open),
        .wlock    (wlock),
        .rlock    (rlock)
    );

    logic [ROUTES-1:0][PINS_MAX-1:0] masks;

    gpio_rt_mask_bank #(
        .NROUTES      (ROUTES),
        .WIDTH        (PINS_MAX),
        .IDX_W        (IDX_W),
        .DEFAULT_MASK (DEF_MASK)
    ) u_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_we   (init_we),
        .init_idx  (init_idx),
        .host_we   (reg_wr && map_hit && map_open),
        .host_idx  (map_idx),
        .host_data (reg_wdata[PINS_MAX-1:0]),
        .masks     (masks)
    );

    logic [ROUTES-1:0][PINS_MAX-1:0] status;

    gpio_rt_status #(.NROUTES(ROUTES), .WIDTH(PINS_MAX), .NPINS(NPINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pin_pending),
        .masks    (masks),
        .status_q (status),
        .irq_q    (route_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (scr_hit) begin
            reg_rdata[WLOCK_BIT] = wlock;
            reg_rdata[RLOCK_BIT] = rlock;
        end else if (map_hit) begin
            if (!rlock) reg_rdata[PINS_MAX-1:0] = masks[map_idx];
        end else if (stat_hit) begin
            reg_rdata[PINS_MAX-1:0] = status[stat_idx];
        end
    end

    assert_rdlock_hides_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rlock && map_hit) |-> (reg_rdata == '0));
    assert_locked_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && map_hit && (wlock || rlock)) |=> $stable(masks));
endmodule

// File: tb/sim_gpio_port_irq_router.sv
module sim_gpio_port_irq_router;
    localparam int CLK_NS = 10;
    localparam int NP     = 7;
    localparam int PIDX   = 0;
    localparam int NR     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    gpio_port_irq_router #(.NPINS(NP), .PORT_IDX(PIDX)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_pending(pend), .reg_wr(wr),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .route_irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string focus = "R1";

    // behavioural reference state
    logic [7:0] m_mask [NR];
    logic [7:0] m_stat [NR];
    logic [7:0] m_irq;
    bit         m_wl, m_rl, m_init;
    int         m_idx;

    function automatic int map_addr(int r);
        return 'h14 + PIDX * 'h20 + 4 * r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mask[r]) begin m_mask[r] = 0; m_stat[r] = 0; end
            m_irq = 0; m_wl = 0; m_rl = 0; m_init = 1; m_idx = 0;
        end else begin
            for (int r = 0; r < NR; r++) begin
                m_stat[r] = pend & m_mask[r] & 8'((1 << NP) - 1);
                m_irq[r]  = (m_stat[r] != 0);
            end
            if (m_init) begin
                m_mask[m_idx] = 8'((1 << NP) - 1);
                m_idx++;
                if (m_idx == NR) m_init = 0;
            end else if (wr) begin
                if (addr == 12'h00C) begin
                    if (wdata[28]) m_wl = 1;
                    if (wdata[27]) m_rl = 1;
                end else begin
                    for (int r = 0; r < NR; r++)
                        if (int'(addr) == map_addr(r) && !m_wl && !m_rl)
                            m_mask[r] = wdata[7:0];
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(output string tag);
        logic [31:0] v = 0;
        tag = "R9";
        if (addr == 12'h00C) begin
            v[28] = m_wl; v[27] = m_rl; tag = "R3";
        end else begin
            for (int r = 0; r < NR; r++) begin
                if (int'(addr) == map_addr(r)) begin
                    tag = m_rl ? "R5" : "R2";
                    v = m_rl ? 0 : {24'h0, m_mask[r]};
                end
                if (int'(addr) == 'h100 + 4 * r) begin
                    tag = "R6";
                    v = {24'h0, m_stat[r]};
                end
            end
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            string t;
            logic [31:0] e;
            e = model_rd(t);
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s/%s rdata addr %h act %h exp %h", focus, t, addr, rdata, e);
            end
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL %s/R8 route_irq act %h exp %h", focus, irq, m_irq);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act %0d cycles exp completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wreg(int a, logic [31:0] d);
        addr = 12'(a); wdata = d; wr = 1; cyc(); wr = 0; wdata = 0;
    endtask

    task automatic rreg(int a);
        addr = 12'(a); cyc(2);
    endtask

    task automatic do_reset();
        rst_n = 0; pend = 0; cyc(3); rst_n = 1;
    endtask

    task automatic directed(string tag, logic [31:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s directed addr %h act %h exp %h", tag, addr, rdata, exp);
        end
    endtask

    initial begin
        cyc(3);
        focus = "R1"; directed("R1", 32'h0);
        rst_n = 1;
        wreg(map_addr(0), 32'h0);            // R1: write during init is dropped
        cyc(NR + 2);
        for (int r = 0; r < NR; r++) begin rreg(map_addr(r)); directed("R1", 32'h7f); end

        focus = "R6";
        pend = 8'h15; rreg('h100); directed("R6", 32'h15);
        pend = 8'h6a; rreg('h104); directed("R6", 32'h6a);

        focus = "R2";
        pend = 0;
        wreg(map_addr(0), 32'hffff_ff01);
        wreg(map_addr(1), 32'h06);
        wreg(map_addr(2), 32'hff);
        wreg(map_addr(3), 32'h00);
        rreg(map_addr(0)); directed("R2", 32'h01);
        rreg(map_addr(2)); directed("R2", 32'hff);

        focus = "R7";
        pend = 8'hff; rreg('h108); directed("R7", 32'h7f);
        pend = 8'h80; rreg('h108); directed("R7", 32'h00);

        focus = "R8";
        pend = 8'h04; cyc(2);
        checks++; if (irq !== 8'hf6) begin errors++; $display("FAIL R8 irq act %h exp %h", irq, 8'hf6); end
        pend = 8'h00; cyc(2);
        checks++; if (irq !== 8'h00) begin errors++; $display("FAIL R8 irq act %h exp %h", irq, 8'h00); end

        focus = "R9";
        wreg('h104, 32'hff); rreg('h104); directed("R9", 32'h0);
        rreg('h200); directed("R9", 32'h0);
        rreg('h016); directed("R9", 32'h0);

        focus = "R3";
        wreg('h00C, 32'h1000_0000); rreg('h00C); directed("R3", 32'h1000_0000);
        wreg('h00C, 32'h0); rreg('h00C); directed("R3", 32'h1000_0000);

        focus = "R4";
        wreg(map_addr(0), 32'h7f);
        rreg(map_addr(0)); directed("R4", 32'h01);
        pend = 8'h7e; rreg('h100); directed("R4", 32'h00);

        focus = "R5";
        do_reset(); cyc(NR + 2);
        wreg('h00C, 32'h0800_0000);
        rreg('h00C); directed("R3", 32'h0800_0000);
        rreg(map_addr(1)); directed("R5", 32'h0);
        wreg(map_addr(1), 32'h00);
        pend = 8'h06; rreg('h104); directed("R4", 32'h06);
        wreg('h00C, 32'h1000_0000);
        rreg('h00C); directed("R3", 32'h1800_0000);

        focus = "R1";
        do_reset(); cyc(NR + 2);
        rreg('h00C); directed("R1", 32'h0);
        rreg(map_addr(7)); directed("R1", 32'h7f);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule